// File: doc/BRIEF.md
# Self-Test Interval Sequencer

This block sequences a built-in processor self-test. The run is split into intervals of a fixed number of test-clock cycles. The test clock is not a separate clock: it is a tick enable derived from the processor clock by a programmable divider. Before starting a run, software sets three values: the divider, the number of intervals and a timeout in processor-clock cycles. It then pulses the start input. The block counts test-clock ticks within each interval and counts completed intervals. At the end of each interval it samples a pass/fail indication from the stimulus-and-compare logic, which lies outside this block.

A run ends in one of two ways: the last interval completes, or the timeout expires. Either way, the block raises a reset request pulse of fixed length and records the outcome in sticky status bits. These bits survive the system reset that the pulse causes. After reset, software reads done, fail and timeout, and the index of the first failing interval. It then clears them with a write-one-to-clear strobe. Only power-on reset clears them otherwise.

The divider setting must keep the test clock at or below 90 MHz. With a divider value D, the tick rate is the processor clock divided by D+1.

Top module: `selftest_sequencer`

## Requirements
- R1: After reset, busy_o, rst_req_o, iv_end_o, iv_index_o and all status outputs are 0.
- R2: A start pulse is accepted only if all three hold: the block is idle with no reset pulse active, cfg_count_i is between 1 and MAX_IV, and cfg_timeout_i is nonzero. When accepted, busy_o is 1 from the next clock edge, and the configuration is captured at that edge.
- R3: A start pulse with cfg_count_i of 0, with cfg_count_i above MAX_IV, or with cfg_timeout_i of 0 leaves busy_o at 0.
- R4: A start pulse that arrives while busy_o or rst_req_o is 1 has no effect: the run in progress ends at its original cycle, and no new run begins after the pulse.
- R5: With divider value D and count N, one test tick occurs every D+1 processor cycles, and each interval lasts CYC_PER_IV ticks. iv_end_o is high in the final cycle of each interval, and iv_index_o advances by one at the edge that ends the interval. A completed run ends exactly CYC_PER_IV·N·(D+1) cycles after the start edge.
- R6: When the last interval ends, busy_o falls and st_done_o is set.
- R7: iv_fail_i is sampled in the final cycle of each interval. If it is 1, st_fail_o is set. st_first_fail_o captures the index of that interval only while st_fail_o is still clear, so later failures do not overwrite it.
- R8: The timeout counts processor cycles, independent of the divider. If the run has not completed T cycles after the start edge, busy_o falls at that edge and st_timeout_o is set. If completion and timeout fall on the same edge, completion wins and only st_done_o is set.
- R9: Each run end raises rst_req_o for exactly RST_LEN cycles, starting at the edge that ends the run.
- R10: The status bits are not changed by sys_n_i. They are cleared only by por_n_i or by clr_i.
- R11: clr_i is a write-one-to-clear strobe. Bit 0 clears done. Bit 1 clears fail and the first-fail index. Bit 2 clears timeout. A set in the same cycle as a clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| por_n_i | input | 1 | Power-on reset, active low; clears everything |
| sys_n_i | input | 1 | System reset, active low; clears run state only |
| cfg_div_i | input | DIV_W | Divider value D; tick every D+1 cycles |
| cfg_count_i | input | IDX_W | Number of intervals to run |
| cfg_timeout_i | input | TO_W | Timeout in processor cycles |
| start_i | input | 1 | Start strobe |
| clr_i | input | 3 | Write-one-to-clear strobes for done, fail, timeout |
| iv_fail_i | input | 1 | Per-interval fail flag from the compare logic |
| busy_o | output | 1 | Run in progress |
| iv_index_o | output | IDX_W | Index of the interval now running |
| iv_end_o | output | 1 | Final cycle of an interval |
| rst_req_o | output | 1 | Reset request pulse |
| st_done_o | output | 1 | Sticky: run completed |
| st_fail_o | output | 1 | Sticky: an interval failed |
| st_timeout_o | output | 1 | Sticky: run aborted by timeout |
| st_first_fail_o | output | IDX_W | Index of the first failing interval |

## Verification
Every result is timed from the edge that samples start_i, called edge 0. busy_o rises at edge 0. iv_end_o is high in the cycle before each interval boundary. A completed run ends at edge CYC_PER_IV·N·(D+1), and a timed-out run ends at edge T; in both cases busy_o falls and rst_req_o and the status rise at that edge. The reset pulse then stays high for RST_LEN cycles. The bench drives and samples on falling edges and counts them from edge 0. It checks that a value has not yet changed one falling edge before it is due, and that it has changed on the falling edge just after.

// File: rtl/stseq_pkg.sv
package stseq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int CLR_W    = 3;
  localparam int CLR_DONE = 0;
  localparam int CLR_FAIL = 1;
  localparam int CLR_TMO  = 2;
endpackage

// File: rtl/stseq_clkdiv.sv
module stseq_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  assign tick_o = run_i && (phase_q == div_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= '0;
    end else if (restart_i || !run_i || tick_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/stseq_ivcount.sv
module stseq_ivcount #(
  parameter int CYC_PER_IV = 1365,
  parameter int IDX_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             iv_end_o,
  output logic             last_o
);
  localparam int CYC_W = $clog2(CYC_PER_IV);
  localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(CYC_PER_IV - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [IDX_W-1:0] idx_q;

  assign iv_end_o = tick_i && (cyc_q == CYC_TOP);
  assign last_o   = iv_end_o && (idx_q == last_idx_i);
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else if (restart_i) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else if (iv_end_o) begin
      cyc_q <= '0;
      idx_q <= idx_q + 1'b1;
    end else if (tick_i) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/stseq_timeout.sv
module stseq_timeout #(
  parameter int TO_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            restart_i,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] elapsed_q;

  assign expire_o = run_i && (elapsed_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      elapsed_q <= '0;
    end else if (restart_i || !run_i) begin
      elapsed_q <= '0;
    end else begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end
endmodule

// File: rtl/stseq_status.sv
module stseq_status #(
  parameter int IDX_W = 5
) (
  input  logic                        clk_i,
  input  logic                        por_n_i,
  input  logic                        set_done_i,
  input  logic                        set_fail_i,
  input  logic [IDX_W-1:0]            fail_idx_i,
  input  logic                        set_tmo_i,
  input  logic [stseq_pkg::CLR_W-1:0] clr_i,
  output logic                        done_o,
  output logic                        fail_o,
  output logic                        tmo_o,
  output logic [IDX_W-1:0]            first_o
);
  import stseq_pkg::*;

  logic             done_q, fail_q, tmo_q;
  logic [IDX_W-1:0] first_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
      first_q <= '0;
    end else begin
      done_q <= set_done_i | (done_q & ~clr_i[CLR_DONE]);
      tmo_q  <= set_tmo_i  | (tmo_q  & ~clr_i[CLR_TMO]);
      if (set_fail_i) begin
        fail_q <= 1'b1;
        if (!fail_q || clr_i[CLR_FAIL]) begin
          first_q <= fail_idx_i;
        end
      end else if (clr_i[CLR_FAIL]) begin
        fail_q  <= 1'b0;
        first_q <= '0;
      end
    end
  end

  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign tmo_o   = tmo_q;
  assign first_o = first_q;
endmodule

// File: rtl/stseq_rstpulse.sv
module stseq_rstpulse #(
  parameter int RST_LEN = 8
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic trig_i,
  output logic req_o
);
  localparam int CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] left_q;
  logic             req_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      req_q  <= 1'b0;
      left_q <= '0;
    end else if (trig_i) begin
      req_q  <= 1'b1;
      left_q <= CNT_W'(RST_LEN - 1);
    end else if (req_q) begin
      if (left_q == '0) begin
        req_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/selftest_sequencer.sv
module selftest_sequencer #(
  parameter int DIV_W      = 4,
  parameter int MAX_IV     = 24,
  parameter int CYC_PER_IV = 1365,
  parameter int TO_W       = 20,
  parameter int RST_LEN    = 8,
  localparam int IDX_W     = $clog2(MAX_IV + 1)
) (
  input  logic                        clk_i,
  input  logic                        por_n_i,
  input  logic                        sys_n_i,
  input  logic [DIV_W-1:0]            cfg_div_i,
  input  logic [IDX_W-1:0]            cfg_count_i,
  input  logic [TO_W-1:0]             cfg_timeout_i,
  input  logic                        start_i,
  input  logic [stseq_pkg::CLR_W-1:0] clr_i,
  input  logic                        iv_fail_i,
  output logic                        busy_o,
  output logic [IDX_W-1:0]            iv_index_o,
  output logic                        iv_end_o,
  output logic                        rst_req_o,
  output logic                        st_done_o,
  output logic                        st_fail_o,
  output logic                        st_timeout_o,
  output logic [IDX_W-1:0]            st_first_fail_o
);
  import stseq_pkg::*;

  localparam logic [IDX_W-1:0] COUNT_MAX = IDX_W'(MAX_IV);

  logic             run_rst_n;
  seq_state_e       state_q;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] last_idx_q;
  logic [TO_W-1:0]  limit_q;
  logic             running, start_ok, tick, iv_end, last_end, expire;
  logic             end_done, end_tmo;
  logic [IDX_W-1:0] idx;

  assign run_rst_n = por_n_i & sys_n_i;
  assign running   = (state_q == SEQ_RUN);

  assign start_ok = start_i && !running && !rst_req_o
                    && (cfg_count_i != '0) && (cfg_count_i <= COUNT_MAX)
                    && (cfg_timeout_i != '0);

  assign end_done = running && last_end;
  assign end_tmo  = running && expire && !last_end;

  always_ff @(posedge clk_i or negedge run_rst_n) begin
    if (!run_rst_n) begin
      state_q    <= SEQ_IDLE;
      div_q      <= '0;
      last_idx_q <= '0;
      limit_q    <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_ok) begin
          state_q    <= SEQ_RUN;
          div_q      <= cfg_div_i;
          last_idx_q <= cfg_count_i - 1'b1;
          limit_q    <= cfg_timeout_i;
        end
        SEQ_RUN: if (end_done || end_tmo) begin
          state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  stseq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_n_i   (run_rst_n),
    .restart_i (start_ok),
    .run_i     (running),
    .div_i     (div_q),
    .tick_o    (tick)
  );

  stseq_ivcount #(.CYC_PER_IV(CYC_PER_IV), .IDX_W(IDX_W)) u_iv (
    .clk_i      (clk_i),
    .rst_n_i    (run_rst_n),
    .restart_i  (start_ok),
    .tick_i     (tick),
    .last_idx_i (last_idx_q),
    .idx_o      (idx),
    .iv_end_o   (iv_end),
    .last_o     (last_end)
  );

  stseq_timeout #(.TO_W(TO_W)) u_tmo (
    .clk_i     (clk_i),
    .rst_n_i   (run_rst_n),
    .restart_i (start_ok),
    .run_i     (running),
    .limit_i   (limit_q),
    .expire_o  (expire)
  );

  stseq_status #(.IDX_W(IDX_W)) u_stat (
    .clk_i      (clk_i),
    .por_n_i    (por_n_i),
    .set_done_i (end_done),
    .set_fail_i (iv_end && iv_fail_i),
    .fail_idx_i (idx),
    .set_tmo_i  (end_tmo),
    .clr_i      (clr_i),
    .done_o     (st_done_o),
    .fail_o     (st_fail_o),
    .tmo_o      (st_timeout_o),
    .first_o    (st_first_fail_o)
  );

  stseq_rstpulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .trig_i  (end_done || end_tmo),
    .req_o   (rst_req_o)
  );

  assign busy_o     = running;
  assign iv_index_o = idx;
  assign iv_end_o   = iv_end;
endmodule

// File: rtl/selftest_sequencer_chk.sv
module selftest_sequencer_chk #(
  parameter int MAX_IV  = 24,
  parameter int RST_LEN = 8,
  parameter int IDX_W   = 5
) (
  input logic             clk_i,
  input logic             por_n_i,
  input logic [2:0]       clr_i,
  input logic             busy_o,
  input logic [IDX_W-1:0] iv_index_o,
  input logic             rst_req_o,
  input logic             st_done_o,
  input logic             st_fail_o,
  input logic             st_timeout_o,
  input logic [IDX_W-1:0] st_first_fail_o
);
  logic [15:0] pulse_cnt_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) pulse_cnt_q <= '0;
    else if (rst_req_o) pulse_cnt_q <= pulse_cnt_q + 1'b1;
    else pulse_cnt_q <= '0;
  end

  assert_idx_in_range_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    busy_o |-> (iv_index_o < IDX_W'(MAX_IV)));

  assert_no_run_in_pulse_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rst_req_o |-> !busy_o);

  assert_req_follows_run_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(rst_req_o) |-> $past(busy_o));

  assert_pulse_length_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(rst_req_o) |-> (pulse_cnt_q == 16'(RST_LEN)));

  assert_end_has_status_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(rst_req_o) |-> (st_done_o || st_timeout_o));

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_done_o && !clr_i[0]) |=> st_done_o);

  assert_fail_sticky_R10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_fail_o && !clr_i[1]) |=> st_fail_o);

  assert_first_kept_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (st_fail_o && !clr_i[1]) |=> $stable(st_first_fail_o));
endmodule

bind selftest_sequencer selftest_sequencer_chk #(
  .MAX_IV(MAX_IV), .RST_LEN(RST_LEN), .IDX_W(IDX_W)
) u_chk (
  .clk_i           (clk_i),
  .por_n_i         (por_n_i),
  .clr_i           (clr_i),
  .busy_o          (busy_o),
  .iv_index_o      (iv_index_o),
  .rst_req_o       (rst_req_o),
  .st_done_o       (st_done_o),
  .st_fail_o       (st_fail_o),
  .st_timeout_o    (st_timeout_o),
  .st_first_fail_o (st_first_fail_o)
);

// File: tb/test_selftest_sequencer.sv
module test_selftest_sequencer;
  localparam int DIV_W = 4, MAX_IV = 24, CYC = 1365, TO_W = 20, RST_LEN = 8;
  localparam int IDX_W = $clog2(MAX_IV + 1);

  typedef struct packed {
    int          div;
    int          n;
    int          tmo;
    logic [31:0] mask;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{div: 0, n: 1,  tmo: 5000,  mask: 32'h0},
    '{div: 1, n: 2,  tmo: 10000, mask: 32'h2},
    '{div: 0, n: 3,  tmo: 10000, mask: 32'h5},
    '{div: 2, n: 2,  tmo: 3000,  mask: 32'h1},
    '{div: 0, n: 24, tmo: 40000, mask: 32'h0080_0000},
    '{div: 0, n: 1,  tmo: 1365,  mask: 32'h0}
  };

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic             sys_n;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [IDX_W-1:0] cfg_count = '0;
  logic [TO_W-1:0]  cfg_tmo = '0;
  logic             start = 1'b0;
  logic [2:0]       clr = '0;
  logic             iv_fail;
  logic             busy, iv_end, rst_req, st_done, st_fail, st_tmo;
  logic [IDX_W-1:0] iv_index, st_first;
  logic [31:0]      fail_mask = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign sys_n   = por_n && !rst_req;
  assign iv_fail = fail_mask[iv_index];

  selftest_sequencer #(
    .DIV_W(DIV_W), .MAX_IV(MAX_IV), .CYC_PER_IV(CYC), .TO_W(TO_W), .RST_LEN(RST_LEN)
  ) i_selftest_sequencer (
    .clk_i(clk), .por_n_i(por_n), .sys_n_i(sys_n),
    .cfg_div_i(cfg_div), .cfg_count_i(cfg_count), .cfg_timeout_i(cfg_tmo),
    .start_i(start), .clr_i(clr), .iv_fail_i(iv_fail),
    .busy_o(busy), .iv_index_o(iv_index), .iv_end_o(iv_end), .rst_req_o(rst_req),
    .st_done_o(st_done), .st_fail_o(st_fail), .st_timeout_o(st_tmo),
    .st_first_fail_o(st_first)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // start strobe; returns at the falling edge just after edge 0
  task automatic kick(input int div, input int n, input int tmo);
    @(negedge clk);
    cfg_div   = DIV_W'(div);
    cfg_count = IDX_W'(n);
    cfg_tmo   = TO_W'(tmo);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr = 3'b111;
    @(negedge clk);
    clr = 3'b000;
  endtask

  task automatic drain_pulse();
    while (rst_req) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=190000 expected=fewer cycles");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !rst_req && !iv_end, "R1 control outputs", {busy, rst_req, iv_end}, 0);
    check(!st_done && !st_fail && !st_tmo && st_first == 0, "R1 status",
          {st_done, st_fail, st_tmo}, 0);
    check(iv_index == 0, "R1 index", iv_index, 0);

    // Vector table walk: R2 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      automatic int len   = CYC * (VECS[v].div + 1);
      automatic int full  = len * VECS[v].n;
      automatic bit exp_done = (full <= VECS[v].tmo);
      automatic int t_end = exp_done ? full : VECS[v].tmo;
      automatic int n_done = exp_done ? VECS[v].n : (VECS[v].tmo / len);
      automatic bit exp_fail = 1'b0;
      automatic int exp_first = 0;
      automatic int plen = 0;
      for (int k = 0; k < 32; k++) begin
        if (k < n_done && VECS[v].mask[k] && !exp_fail) begin
          exp_fail = 1'b1;
          exp_first = k;
        end
      end
      clear_all();
      fail_mask = VECS[v].mask;
      kick(VECS[v].div, VECS[v].n, VECS[v].tmo);
      check(busy, "R2 busy after start", busy, 1);
      repeat (t_end - 1) @(negedge clk);
      check(busy && !rst_req, "R5 still running one cycle before end", busy, 1);
      @(negedge clk);
      check(!busy && rst_req, "R9 end edge busy/req", {busy, rst_req}, 1);
      check(st_done == exp_done, "R6 done", st_done, exp_done);
      check(st_tmo == !exp_done, "R8 timeout", st_tmo, !exp_done);
      check(st_fail == exp_fail, "R7 fail", st_fail, exp_fail);
      check(int'(st_first) == exp_first, "R7 first index", st_first, exp_first);
      while (rst_req) begin
        plen++;
        @(negedge clk);
      end
      check(plen == RST_LEN, "R9 pulse length", plen, RST_LEN);
      check(st_done == exp_done && st_tmo == !exp_done && st_fail == exp_fail,
            "R10 status after system reset", {st_done, st_fail, st_tmo},
            {exp_done, exp_fail, !exp_done});
    end
    fail_mask = '0;

    // R3 invalid starts
    clear_all();
    kick(0, 0, 100);
    check(!busy, "R3 zero count", busy, 0);
    kick(0, MAX_IV + 1, 100);
    check(!busy, "R3 count above max", busy, 0);
    kick(0, 1, 0);
    check(!busy, "R3 zero timeout", busy, 0);

    // R4 start during a run and during the pulse
    kick(0, 1, 5000);
    repeat (99) @(negedge clk);
    cfg_count = IDX_W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (CYC - 101) @(negedge clk);
    check(busy, "R4 run continues", busy, 1);
    @(negedge clk);
    check(!busy && rst_req, "R4 original end cycle", busy, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain_pulse();
    @(negedge clk);
    check(!busy, "R4 start during pulse ignored", busy, 0);

    // R5 interval boundary
    clear_all();
    kick(0, 2, 5000);
    repeat (CYC - 2) @(negedge clk);
    check(!iv_end && iv_index == 0, "R5 no end before last cycle", iv_end, 0);
    @(negedge clk);
    check(iv_end && iv_index == 0, "R5 iv_end in final cycle", iv_end, 1);
    @(negedge clk);
    check(!iv_end && iv_index == 1, "R5 index advances", iv_index, 1);
    repeat (CYC - 1) @(negedge clk);
    check(busy, "R5 second interval running", busy, 1);
    @(negedge clk);
    check(!busy && st_done, "R6 two intervals done", st_done, 1);
    drain_pulse();

    // R11 write-one-to-clear
    clear_all();
    fail_mask = 32'h1;
    kick(0, 1, 5000);
    repeat (CYC) @(negedge clk);
    drain_pulse();
    fail_mask = '0;
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
    check(!st_done && st_fail, "R11 clear done only", {st_done, st_fail}, 1);
    clr = 3'b010;
    @(negedge clk);
    clr = 3'b000;
    check(!st_fail && st_first == 0, "R11 clear fail", st_fail, 0);
    kick(0, 1, 10);
    repeat (9) @(negedge clk);
    @(negedge clk);
    check(st_tmo && !st_done, "R8 short timeout", st_tmo, 1);
    drain_pulse();
    clr = 3'b100;
    @(negedge clk);
    clr = 3'b000;
    check(!st_tmo, "R11 clear timeout", st_tmo, 0);

    // R10 power-on reset clears status
    kick(0, 1, 10);
    repeat (10) @(negedge clk);
    drain_pulse();
    check(st_tmo, "R10 status set before power-on reset", st_tmo, 1);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check(!st_tmo && !st_done && !st_fail, "R10 power-on reset clears",
          {st_done, st_fail, st_tmo}, 0);

    finish_run();
  end
endmodule